// File: doc/BRIEF.md
# I/O Transfer Instruction Pulse Sequencer

This block is the processor-side engine that carries out one programmed input/output instruction on a 12-bit word machine. When a fetched word with the I/O opcode is offered while the block is idle, it latches the word, raises a pause flag that holds off the normal instruction timing, and steps through three time slots of equal length. Inside each slot it may emit one command pulse toward the device selectors, and whether it does so depends on one low-order bit of the instruction. It drives the six-bit device select field onto the bus for the whole transfer.

At the last clock of each slot a strobe samples the shared lines. Data on the input bus is ORed into the accumulator, after clearing it first when the clear line is asserted. A request on the shared skip line is remembered. When the third slot ends the pause flag drops, a one-cycle done pulse appears, and a program-counter increment request is raised with it if any slot saw a skip. The slot timing does not depend on which pulses are enabled.

Instruction bits are named in the big-endian sense (bit 0 is the most significant). In the `instr` vector, bit k of the instruction is `instr[11-k]`.

Top module: `iot_sequencer`

## Requirements
- R1: An instruction is accepted only when `instr_valid` is high, `busy` is low and `instr[11:9]` equals 3'b110. Any other word leaves `busy`, `done`, `strobe` and `iop` low.
- R2: After the accepting clock edge, `busy` is high for exactly 3*SLOT_CYCLES cycles (12 by default), whatever the three gate bits are.
- R3: Slot 0 drives `iop[0]` if `instr[0]` is 1, slot 1 drives `iop[1]` if `instr[1]` is 1, and slot 2 drives `iop[2]` if `instr[2]` is 1. Each pulse is high on slot cycles PULSE_START to PULSE_START+PULSE_LEN-1 (1 and 2 by default), and no pulse is ever high outside its slot.
- R4: `sel_code` equals `instr[8:3]` of the accepted word during every busy cycle and is zero while idle.
- R5: `strobe` is high for a single cycle, on the last cycle of each slot, giving three strobes per instruction, and never together with a pulse.
- R6: At each strobe with `ac_clear` low, the accumulator becomes its previous value ORed with `bus_data`. The accumulator starts from `ac_in`, which is captured at acceptance.
- R7: At a strobe with `ac_clear` high, the accumulator becomes `bus_data` alone.
- R8: `pc_inc` is high in the done cycle exactly when `skip_line` was high at one or more strobes of the instruction. It is a single one-cycle request even if several slots skip.
- R9: `done` is high for exactly one cycle, the first cycle after `busy` falls, and `ac_out` holds the final accumulator from then until the next acceptance.
- R10: `instr_valid` asserted while `busy` is high has no effect: the select code, the pulses and the length of the running transfer are unchanged, and no new transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | A fetched instruction word is presented |
| instr | input | 12 | Instruction word; `instr[11]` is instruction bit 0 |
| ac_in | input | 12 | Accumulator value at the start of the transfer |
| bus_data | input | 12 | Device input data bus, sampled at each strobe |
| ac_clear | input | 1 | Accumulator clear request, sampled at each strobe |
| skip_line | input | 1 | Shared skip request, sampled at each strobe |
| busy | output | 1 | Pause flag: normal timing is held off |
| sel_code | output | 6 | Device select code driven to the bus |
| iop | output | 3 | Command pulses for slots 0, 1 and 2 |
| strobe | output | 1 | End-of-slot sample strobe |
| ac_out | output | 12 | Accumulator result |
| pc_inc | output | 1 | Program-counter increment request, valid with `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The vector table tries single-pulse words for each slot, a word with no pulse bits, a word with all three pulse bits, and a word with a different select field. Together these show that slot length does not follow the gate bits and that each gate bit reaches only its own slot. The per-slot data, clear and skip settings tell OR-merging apart from clear-then-load. They also separate a skip in one slot from skips in several slots, which must still give one increment. Directed cases cover rejected opcodes and a second valid word offered in the middle of a transfer.

// File: rtl/iot_seq_pkg.sv
package iot_seq_pkg;

    localparam int WORD_W    = 12;
    localparam int OPC_W     = 3;
    localparam int OPC_LO    = WORD_W - OPC_W;
    localparam int SEL_W     = 6;
    localparam int SEL_LO    = 3;
    localparam int NUM_SLOTS = 3;
    localparam int SLOT_W    = 2;

    localparam logic [OPC_W-1:0] IOT_OPCODE = 3'b110;

    typedef struct packed {
        logic              pause;
        logic [WORD_W-1:0] instr;
        logic [WORD_W-1:0] ac;
        logic              skip;
        logic              done;
    } seq_state_t;

endpackage

// File: rtl/iot_slot_timer.sv
module iot_slot_timer
    import iot_seq_pkg::*;
#(
    parameter int SLOT_CYCLES = 4,
    parameter int PULSE_START = 1,
    parameter int PULSE_LEN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [SLOT_W-1:0] slot,
    output logic              in_pulse,
    output logic              strobe,
    output logic              last_strobe
);

    localparam int CNT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYCLES - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [CNT_W-1:0]  cnt_d, cnt_q;
    logic [SLOT_W-1:0] slot_d, slot_q;

    always_comb begin
        strobe      = run && (cnt_q == CNT_LAST);
        last_strobe = strobe && (slot_q == SLOT_LAST);
        in_pulse    = run && (int'(cnt_q) >= PULSE_START)
                          && (int'(cnt_q) < PULSE_START + PULSE_LEN);
        cnt_d  = cnt_q;
        slot_d = slot_q;
        if (!run) begin
            cnt_d  = '0;
            slot_d = '0;
        end else if (strobe) begin
            cnt_d  = '0;
            slot_d = last_strobe ? '0 : slot_q + 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slot_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            slot_q <= slot_d;
        end
    end

    assign slot = slot_q;

    // R5
    strobe_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> (cnt_q == '0));

    // R2
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(slot_q) < NUM_SLOTS));

endmodule

// File: rtl/iot_pulse_gate.sv
module iot_pulse_gate
    import iot_seq_pkg::*;
(
    input  logic                 in_pulse,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [NUM_SLOTS-1:0] gate,
    output logic [NUM_SLOTS-1:0] pulse
);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_pulse
        assign pulse[k] = in_pulse && (slot == SLOT_W'(k)) && gate[k];
    end

endmodule

// File: rtl/iot_ac_merge.sv
module iot_ac_merge
    import iot_seq_pkg::*;
(
    input  logic [WORD_W-1:0] acc,
    input  logic [WORD_W-1:0] bus,
    input  logic              clr,
    output logic [WORD_W-1:0] merged
);

    assign merged = (clr ? '0 : acc) | bus;

endmodule

// File: rtl/iot_sequencer.sv
module iot_sequencer
    import iot_seq_pkg::*;
#(
    parameter int SLOT_CYCLES = 4,
    parameter int PULSE_START = 1,
    parameter int PULSE_LEN   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] ac_in,
    input  logic [WORD_W-1:0] bus_data,
    input  logic              ac_clear,
    input  logic              skip_line,
    output logic              busy,
    output logic [SEL_W-1:0]  sel_code,
    output logic [NUM_SLOTS-1:0] iop,
    output logic              strobe,
    output logic [WORD_W-1:0] ac_out,
    output logic              pc_inc,
    output logic              done
);

    seq_state_t        st_d, st_q;
    logic [SLOT_W-1:0] slot;
    logic              in_pulse, last_strobe, accept;
    logic [WORD_W-1:0] ac_merged;

    iot_slot_timer #(
        .SLOT_CYCLES(SLOT_CYCLES),
        .PULSE_START(PULSE_START),
        .PULSE_LEN  (PULSE_LEN)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (st_q.pause),
        .slot       (slot),
        .in_pulse   (in_pulse),
        .strobe     (strobe),
        .last_strobe(last_strobe)
    );

    iot_pulse_gate u_gate (
        .in_pulse(in_pulse),
        .slot    (slot),
        .gate    (st_q.instr[NUM_SLOTS-1:0]),
        .pulse   (iop)
    );

    iot_ac_merge u_merge (
        .acc   (st_q.ac),
        .bus   (bus_data),
        .clr   (ac_clear),
        .merged(ac_merged)
    );

    assign accept = instr_valid && !st_q.pause
                 && (instr[WORD_W-1:OPC_LO] == IOT_OPCODE);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.pause) begin
            if (accept) begin
                st_d.pause = 1'b1;
                st_d.instr = instr;
                st_d.ac    = ac_in;
                st_d.skip  = 1'b0;
            end
        end else if (strobe) begin
            st_d.ac = ac_merged;
            if (skip_line) st_d.skip = 1'b1;
            if (last_strobe) begin
                st_d.pause = 1'b0;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.pause;
    assign sel_code = st_q.pause ? st_q.instr[SEL_LO +: SEL_W] : '0;
    assign ac_out   = st_q.ac;
    assign done     = st_q.done;
    assign pc_inc   = st_q.done && st_q.skip;

    // R3
    iop_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iop));

    // R3
    iop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|iop) |-> busy);

    // R5
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (iop == '0));

    // R4
    sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(sel_code));

    // R9
    done_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    pc_inc_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |-> done);

    // R1
    start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_valid));

endmodule

// File: tb/iot_sequencer_test.sv
module iot_sequencer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] ac_in = '0;
    logic [11:0] bus_data = '0;
    logic        ac_clear = 1'b0;
    logic        skip_line = 1'b0;
    logic        busy, strobe, pc_inc, done;
    logic [5:0]  sel_code;
    logic [2:0]  iop;
    logic [11:0] ac_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    iot_sequencer uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .ac_in(ac_in), .bus_data(bus_data), .ac_clear(ac_clear),
        .skip_line(skip_line), .busy(busy), .sel_code(sel_code), .iop(iop),
        .strobe(strobe), .ac_out(ac_out), .pc_inc(pc_inc), .done(done)
    );

    typedef struct packed {
        logic [11:0] ins;
        logic [11:0] ac;
        logic [11:0] d0;
        logic [11:0] d1;
        logic [11:0] d2;
        logic [2:0]  clr;
        logic [2:0]  skp;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{12'o6341, 12'o0007, 12'o0070, 12'o0000, 12'o0000, 3'b000, 3'b000},
        '{12'o6342, 12'o1234, 12'o0000, 12'o4001, 12'o0000, 3'b010, 3'b010},
        '{12'o6344, 12'o7777, 12'o0000, 12'o0000, 12'o0000, 3'b100, 3'b000},
        '{12'o6340, 12'o0505, 12'o0000, 12'o0000, 12'o0000, 3'b000, 3'b001},
        '{12'o6347, 12'o0001, 12'o0010, 12'o0100, 12'o1000, 3'b001, 3'b101},
        '{12'o6117, 12'o4000, 12'o0001, 12'o0002, 12'o0004, 3'b000, 3'b000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drives one transfer from a negedge; inject >= 0 offers a second word mid-run (R10).
    task automatic run_vec(input vec_t v, input int inject);
        logic [11:0] exp_ac;
        logic        exp_pc;
        exp_ac = v.ac;
        exp_pc = 1'b0;
        for (int k = 0; k < 3; k++) begin
            logic [11:0] dk;
            dk = (k == 0) ? v.d0 : (k == 1) ? v.d1 : v.d2;
            if (v.clr[k]) exp_ac = '0;
            exp_ac = exp_ac | dk;
            exp_pc = exp_pc | v.skp[k];
        end
        instr = v.ins;
        ac_in = v.ac;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        ac_in = '0;
        for (int c = 0; c < 12; c++) begin
            int s;
            int p;
            logic [2:0] exp_iop;
            s = c / 4;
            p = c % 4;
            exp_iop = '0;
            if (p >= 1 && p <= 2 && v.ins[s]) exp_iop[s] = 1'b1;
            bus_data  = (s == 0) ? v.d0 : (s == 1) ? v.d1 : v.d2;
            ac_clear  = (p == 3) ? v.clr[s] : 1'b0;
            skip_line = (p == 3) ? v.skp[s] : 1'b0;
            if (c == inject) begin
                instr_valid = 1'b1;
                instr = 12'o6777;
            end else begin
                instr_valid = 1'b0;
            end
            check("R2 busy during slots", {31'b0, busy}, 32'd1);
            check("R3 pulse pattern", {29'b0, iop}, {29'b0, exp_iop});
            check("R5 strobe timing", {31'b0, strobe}, {31'b0, p == 3});
            check("R4 select code", {26'b0, sel_code}, {26'b0, v.ins[8:3]});
            @(negedge clk);
        end
        instr_valid = 1'b0;
        bus_data = '0;
        ac_clear = 1'b0;
        skip_line = 1'b0;
        check("R2 busy ends", {31'b0, busy}, 32'd0);
        check("R9 done pulse", {31'b0, done}, 32'd1);
        check("R6 R7 accumulator", {20'b0, ac_out}, {20'b0, exp_ac});
        check("R8 pc increment", {31'b0, pc_inc}, {31'b0, exp_pc});
        @(negedge clk);
        check("R9 done single cycle", {31'b0, done}, 32'd0);
        check("R8 increment single", {31'b0, pc_inc}, 32'd0);
        check("R9 accumulator held", {20'b0, ac_out}, {20'b0, exp_ac});
        check("R10 no restart", {31'b0, busy}, 32'd0);
    endtask

    task automatic reject(input logic [11:0] w);
        instr = w;
        instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        for (int c = 0; c < 14; c++) begin
            check("R1 non-I/O word ignored",
                  {28'b0, busy, done, strobe, |iop}, 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset outputs", {23'b0, busy, done, pc_inc, strobe, iop, sel_code == 6'd0},
              32'd1);
        check("R4 reset select", {26'b0, sel_code}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) run_vec(VEC[i], -1);
        reject(12'o5100);
        reject(12'o7000);
        reject(12'o4347);
        run_vec(VEC[0], 5);
        run_vec(VEC[4], 9);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule